// File: doc/BRIEF.md
# DRAM Maintenance Command Scheduler

This block decides when a DRAM gets its periodic refresh and its short ZQ calibration, and runs the handshake that makes each of these commands safe to send. In automatic mode two free-running interval timers raise the due requests. In user mode a configuration input turns those timers off, and maintenance happens only when the user pulses a request strobe.

When an operation is pending, the block asks the command sequencer to close every open bank. Once the sequencer acknowledges, the block presents one maintenance command for a single cycle, tagged with its type. It then holds a busy output for the command's busy time, so that no row opening can start. If both operations are pending, refresh goes first. ZQ follows as soon as the refresh busy time ends, and the banks stay closed in between.

In user mode the busy-time rule is still enforced: a strobe that arrives during a busy time is held until it can be served. An overdue flag warns when no refresh has been issued in user mode for a parameterised number of refresh intervals.

Top module: `dram_maint_sched`

## Requirements
- R1: In automatic mode (`user_mode`=0) a refresh falls due every `T_REFI` cycles, so consecutive refresh commands are exactly `T_REFI` cycles apart when nothing else intervenes.
- R2: In automatic mode a ZQ calibration falls due every `T_ZQI` cycles. Both interval timers start together from reset or on entering automatic mode.
- R3: A pending operation raises `close_req`, which stays high until `close_ack` is sampled high. No command is presented before that acknowledge, and `maint_busy` is high from `close_req` to the end of the busy time.
- R4: After a command, `cmd_valid` stays low and `maint_busy` stays high for exactly `T_RFC` cycles (refresh) or `T_ZQCS` cycles (ZQ). `maint_busy` falls on the next cycle unless another command is chained.
- R5: When refresh and ZQ are both pending, refresh is issued first. ZQ is issued on the cycle after the refresh busy time ends, without a new `close_req`.
- R6: In user mode the interval timers issue nothing. A one-cycle pulse on `usr_ref_req` or `usr_zq_req` starts the close handshake for that operation.
- R7: A user strobe that arrives while a maintenance command is busy is held. Its command is presented on the cycle after that busy time ends.
- R8: In automatic mode the user strobes are ignored.
- R9: `usr_ref_done` and `usr_zq_done` pulse for exactly one cycle, on the last busy cycle of a refresh or a ZQ command respectively, in both modes.
- R10: In user mode, `ref_overdue` rises once `OVD_INTV`*`T_REFI` cycles have passed after the cycle of the last refresh command without another refresh. It clears after the next refresh command, and it is always low in automatic mode.
- R11: During and right after reset, `close_req`, `maint_busy`, `cmd_valid`, both done pulses and `ref_overdue` are low, and `cmd_type` is 2'b00.
- R12: `cmd_type` is 2'b01 for refresh and 2'b10 for ZQ while `cmd_valid` is high, and 2'b00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | 1: maintenance driven by user strobes; 0: internal timers |
| usr_ref_req | input | 1 | User refresh request strobe |
| usr_zq_req | input | 1 | User ZQ calibration request strobe |
| close_ack | input | 1 | Sequencer confirms all banks are closed |
| close_req | output | 1 | Request to close all banks |
| maint_busy | output | 1 | Blocks the sequencer from opening rows |
| cmd_valid | output | 1 | One-cycle maintenance command |
| cmd_type | output | 2 | 01 refresh, 10 ZQ, 00 none |
| usr_ref_done | output | 1 | Refresh busy time completed |
| usr_zq_done | output | 1 | ZQ busy time completed |
| ref_overdue | output | 1 | No refresh within the allowed window in user mode |

## Verification
A wrong pending flag shows at the ports within a few cycles: a command appears with no timer tick or strobe behind it, or an expected command never appears. Either way the command count and the command spacing in a run change. A wrong busy counter moves the falling edge of `maint_busy`, the done pulse and any chained command by whole cycles, so the spacing between commands exposes it on the next command. A state machine that skips the close handshake raises `cmd_valid` without an acknowledge in the same operation. A broken overdue counter moves the rise of `ref_overdue` away from `OVD_INTV`*`T_REFI` cycles after the cycle of the last refresh command.

// File: rtl/dram_maint_pkg.sv
package dram_maint_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLOSE = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } mnt_state_e;

    typedef enum logic [1:0] {
        MT_NONE = 2'b00,
        MT_REF  = 2'b01,
        MT_ZQ   = 2'b10
    } mnt_type_e;

    typedef struct packed {
        mnt_state_e state;
        mnt_type_e  sel;
        logic       ref_pend;
        logic       zq_pend;
    } mnt_ctl_s;

endpackage

// File: rtl/maint_interval_timer.sv
module maint_interval_timer #(
    parameter int PERIOD = 7800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/maint_busy_timer.sv
module maint_busy_timer #(
    parameter int MAXV = 350,
    localparam int W = (MAXV > 1) ? $clog2(MAXV + 1) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (!expired) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/maint_overdue_mon.sv
module maint_overdue_mon #(
    parameter int LIMIT = 70200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic overdue
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    assign overdue = en && (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || clr) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dram_maint_sched.sv
module dram_maint_sched
    import dram_maint_pkg::*;
#(
    parameter int T_REFI   = 7800,
    parameter int T_RFC    = 350,
    parameter int T_ZQI    = 128000,
    parameter int T_ZQCS   = 128,
    parameter int OVD_INTV = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       user_mode,
    input  logic       usr_ref_req,
    input  logic       usr_zq_req,
    input  logic       close_ack,
    output logic       close_req,
    output logic       maint_busy,
    output logic       cmd_valid,
    output logic [1:0] cmd_type,
    output logic       usr_ref_done,
    output logic       usr_zq_done,
    output logic       ref_overdue
);
    localparam int BUSY_MAX = (T_RFC > T_ZQCS) ? T_RFC : T_ZQCS;
    localparam int BW       = (BUSY_MAX > 1) ? $clog2(BUSY_MAX + 1) : 1;
    localparam int OVD_LIM  = OVD_INTV * T_REFI;
    localparam logic [BW-1:0] RFC_LD  = BW'(T_RFC - 1);
    localparam logic [BW-1:0] ZQCS_LD = BW'(T_ZQCS - 1);

    mnt_ctl_s ctl_d, ctl_q;

    logic ref_tick, zq_tick;
    logic ref_set, zq_set;
    logic issuing, wait_end, busy_expired;
    logic [BW-1:0] busy_ld;

    // Interval timers run only in automatic mode
    maint_interval_timer #(.PERIOD(T_REFI)) u_ref_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!user_mode),
        .tick  (ref_tick)
    );

    maint_interval_timer #(.PERIOD(T_ZQI)) u_zq_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!user_mode),
        .tick  (zq_tick)
    );

    assign issuing  = (ctl_q.state == ST_ISSUE);
    assign busy_ld  = (ctl_q.sel == MT_REF) ? RFC_LD : ZQCS_LD;

    maint_busy_timer #(.MAXV(BUSY_MAX)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issuing),
        .load_val (busy_ld),
        .expired  (busy_expired)
    );

    maint_overdue_mon #(.LIMIT(OVD_LIM)) u_ovd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (user_mode),
        .clr     (issuing && (ctl_q.sel == MT_REF)),
        .overdue (ref_overdue)
    );

    assign ref_set  = user_mode ? usr_ref_req : ref_tick;
    assign zq_set   = user_mode ? usr_zq_req  : zq_tick;
    assign wait_end = (ctl_q.state == ST_WAIT) && busy_expired;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.ref_pend || ctl_q.zq_pend) begin
                    ctl_d.state = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (close_ack) begin
                    ctl_d.state = ST_ISSUE;
                    ctl_d.sel   = ctl_q.ref_pend ? MT_REF : MT_ZQ;
                end
            end
            ST_ISSUE: begin
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (busy_expired) begin
                    if (ctl_q.ref_pend || ctl_q.zq_pend) begin
                        // banks are still closed: chain the next command
                        ctl_d.state = ST_ISSUE;
                        ctl_d.sel   = ctl_q.ref_pend ? MT_REF : MT_ZQ;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        // a new request in the issue cycle survives the clear
        ctl_d.ref_pend = (ctl_q.ref_pend && !(issuing && ctl_q.sel == MT_REF)) || ref_set;
        ctl_d.zq_pend  = (ctl_q.zq_pend  && !(issuing && ctl_q.sel == MT_ZQ))  || zq_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, sel: MT_NONE, ref_pend: 1'b0, zq_pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign close_req    = (ctl_q.state == ST_CLOSE);
    assign maint_busy   = (ctl_q.state != ST_IDLE);
    assign cmd_valid    = issuing;
    assign cmd_type     = issuing ? ctl_q.sel : MT_NONE;
    assign usr_ref_done = wait_end && (ctl_q.sel == MT_REF);
    assign usr_zq_done  = wait_end && (ctl_q.sel == MT_ZQ);
endmodule

// File: rtl/dram_maint_checker.sv
module dram_maint_checker #(
    parameter int T_RFC  = 350,
    parameter int T_ZQCS = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       user_mode,
    input logic       close_ack,
    input logic       close_req,
    input logic       maint_busy,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic       usr_ref_done,
    input logic       usr_zq_done,
    input logic       ref_overdue
);
    localparam int GMAX = ((T_RFC > T_ZQCS) ? T_RFC : T_ZQCS) + 2;
    localparam int GW   = $clog2(GMAX + 1);

    logic          closed_q;
    logic [GW-1:0] gap_q;
    logic [GW-1:0] need_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed_q <= 1'b0;
            gap_q    <= '0;
            need_q   <= '0;
            seen_q   <= 1'b0;
        end else begin
            if (close_req && close_ack) begin
                closed_q <= 1'b1;
            end else if (!maint_busy) begin
                closed_q <= 1'b0;
            end
            if (cmd_valid) begin
                gap_q  <= GW'(1);
                seen_q <= 1'b1;
                need_q <= (cmd_type == 2'b01) ? GW'(T_RFC) : GW'(T_ZQCS);
            end else if (gap_q != GW'(GMAX)) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    a_r3_cmd_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> closed_q);
    a_r3_close_held: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && !close_ack) |=> close_req);
    a_r3_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> maint_busy);
    a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen_q) |-> (gap_q > need_q));
    a_r12_type_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_type == 2'b01 || cmd_type == 2'b10));
    a_r12_type_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_type == 2'b00));
    a_r9_ref_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        usr_ref_done |=> !usr_ref_done);
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_ref_done || usr_zq_done) |-> maint_busy);
    a_r10_overdue_user: assert property (@(posedge clk) disable iff (!rst_n)
        ref_overdue |-> user_mode);
endmodule

bind dram_maint_sched dram_maint_checker #(
    .T_RFC  (T_RFC),
    .T_ZQCS (T_ZQCS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .user_mode    (user_mode),
    .close_ack    (close_ack),
    .close_req    (close_req),
    .maint_busy   (maint_busy),
    .cmd_valid    (cmd_valid),
    .cmd_type     (cmd_type),
    .usr_ref_done (usr_ref_done),
    .usr_zq_done  (usr_zq_done),
    .ref_overdue  (ref_overdue)
);

// File: tb/tb_dram_maint_sched.sv
module tb_dram_maint_sched;
    localparam int CLK_PERIOD = 10;
    localparam int REFI = 40;
    localparam int RFC  = 6;
    localparam int ZQI  = 100;
    localparam int ZQCS = 4;
    localparam int OVD  = 3;
    localparam int LIM  = OVD * REFI;

    typedef struct packed {
        logic       is_zq;
        logic [3:0] dly;
    } vec_t;
    localparam vec_t VEC [4] = '{'{1'b0, 4'd0}, '{1'b1, 4'd2}, '{1'b0, 4'd3}, '{1'b1, 4'd0}};

    logic clk, rst_n, user_mode, usr_ref_req, usr_zq_req, close_ack;
    logic close_req, maint_busy, cmd_valid, usr_ref_done, usr_zq_done, ref_overdue;
    logic [1:0] cmd_type;
    logic auto_ack, ack_auto_q, ack_manual, close_prev;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_log = 0, n_close_rise = 0, n_ref_done = 0, n_zq_done = 0;
    int log_cyc [32];
    logic [1:0] log_typ [32];

    dram_maint_sched #(
        .T_REFI(REFI), .T_RFC(RFC), .T_ZQI(ZQI), .T_ZQCS(ZQCS), .OVD_INTV(OVD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
        .usr_ref_req(usr_ref_req), .usr_zq_req(usr_zq_req), .close_ack(close_ack),
        .close_req(close_req), .maint_busy(maint_busy), .cmd_valid(cmd_valid),
        .cmd_type(cmd_type), .usr_ref_done(usr_ref_done), .usr_zq_done(usr_zq_done),
        .ref_overdue(ref_overdue)
    );

    assign close_ack = auto_ack ? ack_auto_q : ack_manual;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        ack_auto_q = 1'b0;
        close_prev = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cmd_valid && n_log < 32) begin
                log_cyc[n_log] = cyc;
                log_typ[n_log] = cmd_type;
                n_log++;
            end
            if (close_req && !close_prev) n_close_rise++;
            close_prev = close_req;
            if (usr_ref_done) n_ref_done++;
            if (usr_zq_done) n_zq_done++;
            ack_auto_q = close_req;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // user-mode operation with a given acknowledge delay
    task automatic run_user_op(input bit is_zq, input int dly);
        int w;
        int n;
        int dn;
        int busy_len;
        busy_len = is_zq ? ZQCS : RFC;
        if (is_zq) usr_zq_req = 1'b1; else usr_ref_req = 1'b1;
        step();
        usr_zq_req  = 1'b0;
        usr_ref_req = 1'b0;
        w = 0;
        while (!close_req && w < 10) begin step(); w++; end
        chk(close_req == 1'b1, "R6", int'(close_req), 1, "close_req after strobe");
        for (int d = 0; d < dly; d++) begin
            chk(close_req && !cmd_valid, "R3", int'(cmd_valid), 0, "no command before ack");
            step();
        end
        ack_manual = 1'b1;
        step();
        ack_manual = 1'b0;
        chk(cmd_valid == 1'b1, "R3", int'(cmd_valid), 1, "command after ack");
        chk(cmd_type == (is_zq ? 2'b10 : 2'b01), "R12", int'(cmd_type), is_zq ? 2 : 1, "cmd_type code");
        n = 0;
        dn = 0;
        step();
        while (maint_busy && n < 50) begin
            if (is_zq ? usr_zq_done : usr_ref_done) dn++;
            n++;
            step();
        end
        chk(n == busy_len, "R4", n, busy_len, "busy cycles after command");
        chk(dn == 1, "R9", dn, 1, "done pulse count");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        int s;
        bit reclose;
        rst_n = 1'b0; user_mode = 1'b0; usr_ref_req = 1'b0; usr_zq_req = 1'b0;
        ack_manual = 1'b0; auto_ack = 1'b1;
        repeat (3) step();
        chk(!close_req && !maint_busy, "R11", int'(maint_busy), 0, "idle in reset");
        chk(!cmd_valid && cmd_type == 2'b00, "R11", int'(cmd_type), 0, "no command in reset");
        chk(!usr_ref_done && !usr_zq_done && !ref_overdue, "R11", int'(ref_overdue), 0, "flags in reset");
        rst_n = 1'b1;
        step();
        chk(!maint_busy && !cmd_valid, "R11", int'(maint_busy), 0, "idle after reset");

        // automatic mode; strobes must be ignored (R8)
        repeat (9) step();
        usr_ref_req = 1'b1; usr_zq_req = 1'b1;
        step();
        usr_ref_req = 1'b0; usr_zq_req = 1'b0;
        repeat (210) step();
        chk(n_log == 7, "R8", n_log, 7, "auto command count, strobes ignored");
        if (n_log == 7) begin
            chk(log_typ[0] == 2'b01 && log_typ[1] == 2'b01, "R1", int'(log_typ[1]), 1, "first refreshes");
            chk(log_cyc[1] - log_cyc[0] == REFI, "R1", log_cyc[1] - log_cyc[0], REFI, "refresh interval");
            chk(log_cyc[3] - log_cyc[0] == 2 * REFI, "R1", log_cyc[3] - log_cyc[0], 2 * REFI, "third refresh");
            chk(log_typ[2] == 2'b10, "R2", int'(log_typ[2]), 2, "first ZQ type");
            chk(log_cyc[2] - log_cyc[0] == ZQI - REFI, "R2", log_cyc[2] - log_cyc[0], ZQI - REFI, "ZQ timing");
            chk(log_typ[5] == 2'b01 && log_typ[6] == 2'b10, "R5", int'(log_typ[5]), 1, "refresh before ZQ");
            chk(log_cyc[5] - log_cyc[0] == 4 * REFI, "R1", log_cyc[5] - log_cyc[0], 4 * REFI, "fifth refresh");
            chk(log_cyc[6] - log_cyc[5] == RFC + 1, "R5", log_cyc[6] - log_cyc[5], RFC + 1, "ZQ chained");
        end
        chk(n_close_rise == 6, "R5", n_close_rise, 6, "one close for chained pair");
        chk(n_ref_done == 5 && n_zq_done == 2, "R9", n_ref_done, 5, "done pulses in auto mode");
        chk(ref_overdue == 1'b0, "R10", int'(ref_overdue), 0, "overdue low in auto mode");

        // user mode: timers silent (R6)
        user_mode = 1'b1;
        auto_ack  = 1'b0;
        step();
        base = n_log;
        repeat (80) step();
        chk(n_log == base, "R6", n_log - base, 0, "no timer commands in user mode");

        // vector table of user operations
        for (int i = 0; i < 4; i++) begin
            run_user_op(VEC[i].is_zq, int'(VEC[i].dly));
        end

        // R7: ZQ strobe during refresh busy time
        usr_ref_req = 1'b1;
        step();
        usr_ref_req = 1'b0;
        s = 0;
        while (!close_req && s < 10) begin step(); s++; end
        ack_manual = 1'b1;
        step();
        ack_manual = 1'b0;
        chk(cmd_valid && cmd_type == 2'b01, "R7", int'(cmd_type), 1, "refresh issued");
        usr_zq_req = 1'b1;
        step();
        usr_zq_req = 1'b0;
        s = 1;
        reclose = 1'b0;
        while (!cmd_valid && s < 50) begin
            if (close_req) reclose = 1'b1;
            step();
            s++;
        end
        chk(s == RFC + 1, "R7", s, RFC + 1, "held ZQ issued after busy time");
        chk(cmd_type == 2'b10, "R7", int'(cmd_type), 2, "held command type");
        chk(!reclose, "R7", int'(reclose), 0, "no second close");
        s = 0;
        while (maint_busy && s < 50) begin step(); s++; end

        // R10: overdue window
        run_user_op(1'b0, 0);
        repeat (LIM - RFC - 1) step();
        chk(ref_overdue == 1'b0, "R10", int'(ref_overdue), 0, "overdue not yet");
        step();
        chk(ref_overdue == 1'b1, "R10", int'(ref_overdue), 1, "overdue raised");
        run_user_op(1'b0, 1);
        chk(ref_overdue == 1'b0, "R10", int'(ref_overdue), 0, "overdue cleared by refresh");

        finish_run();
    end
endmodule